// File: doc/BRIEF.md
# Shared-Period Edge-List PWM Generator

This block drives a group of PWM outputs that share one frame period. It has one timer for all channels. The timer works from a short list of edge events instead of one comparator per channel. Each list entry gives two things: a delay in clock cycles until the following event, and a mask of the channels that rise at that event. Entry 0 opens every frame and drives all outputs low. Later entries switch on the channels named in their masks, so every channel gives one pulse per frame. The pulse ends when the frame ends. Channels whose edges fall in the same cycle share one entry. The list therefore needs only as many entries as there are distinct edge times, plus the frame-start entry.

There are two list banks. One bank plays while the host fills the other through a valid/ready write stream. The host must order the entries before it writes them. A one-cycle swap request asks the block to exchange the banks, and the exchange happens only at a frame boundary. Until the exchange takes place, the request stays pending. While it is pending the write stream applies back-pressure by holding `wr_ready` low, and `bank_free` reads low. A write that is presented while `wr_ready` is low stays on the port and is accepted once `wr_ready` rises again. The frame period is the sum of the effective delays in the playing list.

Top module: `edge_list_pwm`

## Requirements
- R1: After reset, `pwm_out` is all zeros, `wr_ready` is 1 and `bank_free` is 1. Bank 0 is playing and holds all-zero entries.
- R2: At the event of entry 0, every bit of `pwm_out` goes to 0. The mask of entry 0 is ignored.
- R3: At the event of an entry with index above 0, each output `pwm_out[c]` whose mask bit c is 1 goes to 1. All other outputs keep their level.
- R4: The delay field of an entry sets how many cycles pass from its event to the next event. A delay of 0 acts as a delay of 1.
- R5: The event after an entry with the last flag set is entry 0. The event after entry DEPTH-1 is also entry 0. The frame period equals the sum of the effective delays from entry 0 through the last entry.
- R6: `pwm_out` changes only on the clock edge that closes an event cycle. Each channel is high for the sum of the delays from its first rising entry to the end of the frame.
- R7: A swap request that is not taken at once becomes pending. While a swap is pending, `bank_free` and `wr_ready` are 0 and the playing bank does not change.
- R8: A swap is taken in the cycle of the last entry's event if a swap is pending or is requested in that same cycle. The new bank's entry 0 then plays as the next event, and `bank_free` is 1 in the following cycle.
- R9: An accepted write (`wr_valid` and `wr_ready` both 1) stores the delay, mask and last flag at `wr_idx` of the bank that is not playing. It does not change the pattern that is playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Entry write offered |
| wr_ready | output | 1 | Entry write can be accepted |
| wr_idx | input | AW | Entry index in the inactive bank |
| wr_delta | input | DW | Cycles from this event to the next |
| wr_mask | input | NCH | Channels that rise at this event |
| wr_last | input | 1 | Marks the final entry of the frame |
| swap_req | input | 1 | One-cycle request to exchange the banks |
| bank_free | output | 1 | Inactive bank may be written, with no swap pending |
| pwm_out | output | NCH | Registered PWM outputs |

## Verification
Two functions can land in the same cycle: the swap request from the host and the event of the playing list's last entry. The bench detects a frame start from the common falling edge of the outputs, then counts forward so that `swap_req` is high in exactly the last-entry event cycle. The correct result is that the swap is taken immediately. `bank_free` is still 1 in the next cycle, and the next frame already has the new list's duty cycles. A design that misses the coincidence would hold the swap pending for a whole frame. In a separate case, a swap is requested well inside a frame to show pending back-pressure and a later exchange.

// File: rtl/elp_pkg.sv
package elp_pkg;
  localparam int unsigned ELP_NCH_DEF   = 8;
  localparam int unsigned ELP_DW_DEF    = 16;
  localparam int unsigned ELP_DEPTH_DEF = 16;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_id_t;

  function automatic bank_id_t other_bank(input bank_id_t b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/elp_bank_store.sv
module elp_bank_store #(
  parameter int unsigned NCH   = elp_pkg::ELP_NCH_DEF,
  parameter int unsigned DW    = elp_pkg::ELP_DW_DEF,
  parameter int unsigned DEPTH = elp_pkg::ELP_DEPTH_DEF,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  elp_pkg::bank_id_t wr_bank,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_delta,
  input  logic [NCH-1:0]    wr_mask,
  input  logic              wr_last,
  input  elp_pkg::bank_id_t rd_bank,
  input  logic [AW-1:0]     rd_idx,
  output logic [DW-1:0]     rd_delta,
  output logic [NCH-1:0]    rd_mask,
  output logic              rd_last
);
  localparam int unsigned NBANK = 2;

  logic [DW-1:0]  delta_q [NBANK][DEPTH];
  logic [NCH-1:0] mask_q  [NBANK][DEPTH];
  logic           last_q  [NBANK][DEPTH];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel_w;
    assign sel_w = wr_en && (wr_bank == elp_pkg::bank_id_t'(b));

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          delta_q[b][e] <= '0;
          mask_q[b][e]  <= '0;
          last_q[b][e]  <= 1'b0;
        end else if (sel_w && (wr_idx == AW'(e))) begin
          delta_q[b][e] <= wr_delta;
          mask_q[b][e]  <= wr_mask;
          last_q[b][e]  <= wr_last;
        end
      end
    end
  end

  always_comb begin
    rd_delta = delta_q[rd_bank][rd_idx];
    rd_mask  = mask_q[rd_bank][rd_idx];
    rd_last  = last_q[rd_bank][rd_idx];
  end
endmodule

// File: rtl/elp_sequencer.sv
module elp_sequencer #(
  parameter int unsigned DW    = elp_pkg::ELP_DW_DEF,
  parameter int unsigned DEPTH = elp_pkg::ELP_DEPTH_DEF,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ent_delta,
  input  logic          ent_last,
  output logic          fire,
  output logic          at_end,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] cnt
);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [DW-1:0] delta_eff;

  assign fire      = (cnt == '0);
  assign at_end    = ent_last || (ptr == PTR_MAX);
  assign delta_eff = (ent_delta == '0) ? DW'(1) : ent_delta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ptr <= '0;
    end else if (fire) begin
      cnt <= delta_eff - DW'(1);
      ptr <= at_end ? '0 : ptr + AW'(1);
    end else begin
      cnt <= cnt - DW'(1);
    end
  end
endmodule

// File: rtl/elp_swap_ctrl.sv
module elp_swap_ctrl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_req,
  input  logic              frame_end,
  output logic              swap_pend,
  output elp_pkg::bank_id_t play_bank
);
  logic take;

  assign take = frame_end && (swap_pend || swap_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swap_pend <= 1'b0;
      play_bank <= elp_pkg::BANK_A;
    end else begin
      swap_pend <= take ? 1'b0 : (swap_pend || swap_req);
      if (take) play_bank <= elp_pkg::other_bank(play_bank);
    end
  end
endmodule

// File: rtl/elp_out_stage.sv
module elp_out_stage #(
  parameter int unsigned NCH = elp_pkg::ELP_NCH_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           frame_head,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] pwm
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm <= '0;
    end else if (fire) begin
      pwm <= frame_head ? '0 : (pwm | mask);
    end
  end
endmodule

// File: rtl/edge_list_pwm.sv
module edge_list_pwm #(
  parameter int unsigned NCH   = elp_pkg::ELP_NCH_DEF,
  parameter int unsigned DW    = elp_pkg::ELP_DW_DEF,
  parameter int unsigned DEPTH = elp_pkg::ELP_DEPTH_DEF,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [AW-1:0]  wr_idx,
  input  logic [DW-1:0]  wr_delta,
  input  logic [NCH-1:0] wr_mask,
  input  logic           wr_last,
  input  logic           swap_req,
  output logic           bank_free,
  output logic [NCH-1:0] pwm_out
);
  elp_pkg::bank_id_t play_bank;
  logic              swap_pend;
  logic              fire;
  logic              at_end;
  logic [AW-1:0]     ptr;
  logic [DW-1:0]     cnt;
  logic [DW-1:0]     ent_delta;
  logic [NCH-1:0]    ent_mask;
  logic              ent_last;
  logic              wr_en;

  assign wr_ready  = !swap_pend;
  assign bank_free = !swap_pend;
  assign wr_en     = wr_valid && wr_ready;

  elp_bank_store #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_bank  (elp_pkg::other_bank(play_bank)),
    .wr_idx   (wr_idx),
    .wr_delta (wr_delta),
    .wr_mask  (wr_mask),
    .wr_last  (wr_last),
    .rd_bank  (play_bank),
    .rd_idx   (ptr),
    .rd_delta (ent_delta),
    .rd_mask  (ent_mask),
    .rd_last  (ent_last)
  );

  elp_sequencer #(.DW(DW), .DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_delta (ent_delta),
    .ent_last  (ent_last),
    .fire      (fire),
    .at_end    (at_end),
    .ptr       (ptr),
    .cnt       (cnt)
  );

  elp_swap_ctrl u_swap (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_req  (swap_req),
    .frame_end (fire && at_end),
    .swap_pend (swap_pend),
    .play_bank (play_bank)
  );

  elp_out_stage #(.NCH(NCH)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .frame_head (ptr == '0),
    .mask       (ent_mask),
    .pwm        (pwm_out)
  );
endmodule

// File: rtl/elp_checker.sv
module elp_checker #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fire,
  input logic           at_end,
  input logic [AW-1:0]  ptr,
  input logic [DW-1:0]  cnt,
  input logic           swap_pend,
  input logic           play_bank,
  input logic           wr_ready,
  input logic [NCH-1:0] pwm_out
);
  a_r2_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ptr == '0) |=> (pwm_out == '0));

  a_r3_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ptr != '0) |=> ((pwm_out & $past(pwm_out)) == $past(pwm_out)));

  a_r6_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pwm_out));

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && at_end) |=> (ptr == '0));

  a_r7_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && at_end) |=> $stable(play_bank));

  a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pend |-> !wr_ready);

  a_r8_swap_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && at_end && swap_pend) |=> (!swap_pend && play_bank != $past(play_bank)));
endmodule

bind edge_list_pwm elp_checker #(.NCH(NCH), .DW(DW), .AW(AW)) u_elp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (fire),
  .at_end    (at_end),
  .ptr       (ptr),
  .cnt       (cnt),
  .swap_pend (swap_pend),
  .play_bank (play_bank),
  .wr_ready  (wr_ready),
  .pwm_out   (pwm_out)
);

// File: tb/test_edge_list_pwm.sv
module test_edge_list_pwm;
  localparam int NCH = 8;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_valid = 1'b0;
  logic           wr_ready;
  logic [AW-1:0]  wr_idx = '0;
  logic [DW-1:0]  wr_delta = '0;
  logic [NCH-1:0] wr_mask = '0;
  logic           wr_last = 1'b0;
  logic           swap_req = 1'b0;
  logic           bank_free;
  logic [NCH-1:0] pwm_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  int ld [DEPTH];
  int lm [DEPTH];
  int ln;

  always #4 clk = ~clk;

  edge_list_pwm #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) i_edge_list_pwm (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_delta(wr_delta), .wr_mask(wr_mask), .wr_last(wr_last),
    .swap_req(swap_req), .bank_free(bank_free), .pwm_out(pwm_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired at cycle %0d (exp finish earlier)", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int period();
    int s = 0;
    for (int k = 0; k < ln; k++) s += eff(ld[k]);
    return s;
  endfunction

  function automatic int exp_high(input int c);
    int s = 0;
    bool_loop: for (int k = 1; k < ln; k++) begin
      if (lm[k][c]) begin
        for (int j = k; j < ln; j++) s += eff(ld[j]);
        break;
      end
    end
    return s;
  endfunction

  task automatic set_list(input int n, input int d0, input int m0, input int d1, input int m1,
                          input int d2, input int m2, input int d3, input int m3);
    ln = n;
    ld[0] = d0; lm[0] = m0; ld[1] = d1; lm[1] = m1;
    ld[2] = d2; lm[2] = m2; ld[3] = d3; lm[3] = m3;
  endtask

  task automatic write_entry(input int idx, input int d, input int m, input bit l);
    bit r;
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = AW'(idx); wr_delta = DW'(d); wr_mask = NCH'(m); wr_last = l;
    forever begin
      r = wr_ready;
      @(negedge clk);
      if (r) break;
    end
    wr_valid = 1'b0;
  endtask

  task automatic write_list();
    for (int k = 0; k < ln; k++) write_entry(k, ld[k], lm[k], k == ln - 1);
  endtask

  task automatic pulse_swap();
    @(negedge clk);
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
  endtask

  task automatic wait_free();
    while (!bank_free) @(negedge clk);
  endtask

  task automatic wait_fall();
    logic [NCH-1:0] prev;
    @(negedge clk);
    prev = pwm_out;
    forever begin
      @(negedge clk);
      if (prev != '0 && pwm_out == '0) break;
      prev = pwm_out;
    end
  endtask

  task automatic measure(input string req);
    int p = period();
    int hi [NCH];
    for (int c = 0; c < NCH; c++) hi[c] = 0;
    for (int t = 0; t < p; t++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pwm_out[c]) hi[c]++;
    end
    for (int c = 0; c < NCH; c++) check($sformatf("%s ch%0d high cycles", req, c), hi[c], exp_high(c));
  endtask

  task automatic settle();
    repeat (2 * period() + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pwm_out after reset", int'(pwm_out), 0);
    check("R1 wr_ready after reset", int'(wr_ready), 1);
    check("R1 bank_free after reset", int'(bank_free), 1);
    repeat (20) @(negedge clk);
    check("R1 zero bank keeps outputs low", int'(pwm_out), 0);
  endtask

  task automatic t_basic();
    int n;
    set_list(4, 10, 8'hFF, 5, 8'h03, 20, 8'h0C, 15, 8'hF0);
    write_list();
    pulse_swap();
    wait_free();
    settle();
    measure("R3 R6 basic");
    wait_fall();
    n = 0;
    wait_fall_count: begin
      logic [NCH-1:0] prev;
      prev = pwm_out;
      forever begin
        @(negedge clk);
        n++;
        if (prev != '0 && pwm_out == '0) break;
        prev = pwm_out;
      end
    end
    check("R5 frame period", n, 50);
    wait_fall();
    check("R2 all low at frame start", int'(pwm_out), 0);
    repeat (10) @(negedge clk);
    check("R4 first rise after entry0 delta", int'(pwm_out), 8'h03);
  endtask

  task automatic t_two_entry();
    set_list(2, 7, 0, 9, 8'hFF, 0, 0, 0, 0);
    write_list();
    pulse_swap();
    wait_free();
    settle();
    measure("R5 two-entry");
  endtask

  task automatic t_zero_delta();
    set_list(3, 0, 0, 4, 8'h01, 0, 8'h02, 0, 0);
    write_list();
    pulse_swap();
    wait_free();
    settle();
    measure("R4 zero delta");
  endtask

  task automatic t_pending();
    set_list(4, 10, 0, 5, 8'h03, 20, 8'h0C, 15, 8'hF0);
    write_list();
    // playing list is still the zero-delta one: duties 5,1 over 6
    ln = 3; ld[0] = 0; lm[0] = 0; ld[1] = 4; lm[1] = 8'h01; ld[2] = 0; lm[2] = 8'h02;
    measure("R9 writes leave playback");
    ln = 4; ld[0] = 10; lm[0] = 0; ld[1] = 5; lm[1] = 8'h03; ld[2] = 20; lm[2] = 8'h0C;
    wait_fall();
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
    check("R7 bank_free low while pending", int'(bank_free), 0);
    wr_valid = 1'b1;
    check("R7 wr_ready low while pending", int'(wr_ready), 0);
    @(negedge clk);
    wr_valid = 1'b0;
    wait_free();
    settle();
    measure("R7 R8 after pending swap");
  endtask

  task automatic t_same_cycle();
    // basic list (P=50, last delta 15) is playing
    wait_fall();
    set_list(2, 7, 0, 9, 8'hFF, 0, 0, 0, 0);
    repeat (50 - 15 - 1) @(negedge clk);
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
    check("R8 swap taken in last-entry cycle", int'(bank_free), 1);
    repeat (20) @(negedge clk);
    measure("R8 new list after same-cycle swap");
  endtask

  task automatic t_prep_same_cycle();
    // load the two-entry list into the inactive bank first, then the basic list plays
    set_list(2, 7, 0, 9, 8'hFF, 0, 0, 0, 0);
    write_list();
    check("R9 inactive bank write accepted", int'(wr_ready), 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_two_entry();
    t_zero_delta();
    t_pending();
    t_prep_same_cycle();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule